// File: doc/BRIEF.md
# Keyed I/O-Window Configuration Space Mapper

This block is an I/O-port slave for the older, window-style configuration access method. Two byte-wide control registers sit in I/O space. The enable register holds a key in its upper nibble and a function number in bits 3:1. The forward register holds the target bus number. When the key is non-zero, a 4 KB I/O window at 0xC000–0xCFFF is mapped onto configuration space. Address bits 11:8 pick one of 16 devices, and bits 7:0 pick the register.

A claimed window access becomes one configuration request on a simple request/response interface. The request carries bus, device, function, the dword-aligned register offset, byte enables built from the access size and the low address bits, and write data moved to its byte lane. Read data comes back right-justified. If the responder flags that no device answered, the read returns all ones. Software detects the method by writing zero to both control ports and reading zero back. It closes the window by writing zero to the enable port after every access.

On the I/O side, one request is accepted at a time. The block claims it in the same cycle (`io_hit`) and reports completion with a one-cycle `io_done` pulse. A new request is issued once the previous `io_done` has been seen.

Top module: `cfg2_port_mapper`

## Requirements
- R1: After reset, both control registers read 0x00 and accesses in 0xC000–0xCFFF are not claimed.
- R2: A byte write to port 0xCF8 (enable) or 0xCFA (forward) stores the full byte, and a byte read returns it zero-extended. Writing 0x00 reads back 0x00. A control access completes with `io_done` on the cycle after the request cycle.
- R3: While the enable register's upper nibble is zero, window accesses are not claimed and no configuration request is issued, whatever bits 3:0 hold.
- R4: While the key is non-zero, a window access requests device = address bits 11:8, register = address bits 7:2 with two zero low bits, function = enable register bits 3:1, bus = forward register.
- R5: `io_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Byte enables are: one bit at address bits 1:0 for a byte; 0011 or 1100 chosen by address bit 1 for a word (bit 0 ignored); 1111 for a dword (bits 1:0 ignored).
- R6: Write data is taken right-justified from `io_wdata`, masked to the access size, and placed on the lanes its byte enables select.
- R7: Read data is shifted down from the selected lanes and returned right-justified, with bits above the access size cleared.
- R8: A read answered with `cfg_err` returns 0xFFFFFFFF on `io_rdata`, whatever the size.
- R9: Addresses outside the window and other than the two control ports, including 0xCF9, are not claimed.
- R10: Control ports are claimed only for byte accesses. `io_size` = 3 is never claimed.
- R11: `cfg_req` and its fields stay steady until `cfg_ack`. An acknowledge in the first request cycle is accepted. `io_done` pulses for one cycle on the cycle after the acknowledge, and `cfg_req` is low by then.
- R12: A request raised while a window access is outstanding is not claimed and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | I/O access request, one cycle |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O port address |
| io_size | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| io_wdata | input | 32 | Right-justified write data |
| io_hit | output | 1 | Access claimed this cycle |
| io_done | output | 1 | Claimed access complete |
| io_rdata | output | 32 | Right-justified read data, valid with io_done on reads |
| cfg_req | output | 1 | Configuration request, held until acknowledged |
| cfg_wr | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 4 | Target device |
| cfg_func | output | 3 | Target function |
| cfg_reg | output | 8 | Dword-aligned register offset |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-placed write data |
| cfg_ack | input | 1 | Request accepted and complete |
| cfg_err | input | 1 | No device responded |
| cfg_rdata | input | 32 | Lane-placed read data |

## Verification
Two things can share one cycle: a new request is launched on `cfg_req`, and the responder's acknowledge completes it. The bench provokes this with a zero-latency responder that acknowledges in the first request cycle. It then checks that `io_done` arrives exactly one cycle later and that the data is correct. Separately, an I/O request can arrive while a window access is still outstanding. The bench raises a control write against a slow responder and checks that it is not claimed, and that the enable register reads back unchanged afterwards.

// File: rtl/cfg2_pkg.sv
package cfg2_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        DEC_NONE,
        DEC_KEYREG,
        DEC_BUSREG,
        DEC_WINDOW
    } dec_kind_e;

    typedef enum logic {
        XF_IDLE,
        XF_WAIT
    } xfer_state_e;

    // Byte offset of the lowest enabled lane.
    function automatic logic [1:0] lane_offset(input xfer_size_e sz, input logic [1:0] lo);
        case (sz)
            SZ_BYTE: lane_offset = lo;
            SZ_WORD: lane_offset = {lo[1], 1'b0};
            default: lane_offset = 2'd0;
        endcase
    endfunction

    function automatic logic [3:0] lane_enables(input xfer_size_e sz, input logic [1:0] lo);
        logic [3:0] base;
        case (sz)
            SZ_BYTE: base = 4'b0001;
            SZ_WORD: base = 4'b0011;
            default: base = 4'b1111;
        endcase
        lane_enables = base << lane_offset(sz, lo);
    endfunction

    function automatic logic [31:0] size_mask(input xfer_size_e sz);
        case (sz)
            SZ_BYTE: size_mask = 32'h0000_00FF;
            SZ_WORD: size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfg2_ctrl_regs.sv
module cfg2_ctrl_regs #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_we,
    input  logic             bus_we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] key_q,
    output logic [REG_W-1:0] bus_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
            bus_q <= '0;
        end else begin
            if (key_we) key_q <= wdata;
            if (bus_we) bus_q <= wdata;
        end
    end
endmodule

// File: rtl/cfg2_decode.sv
module cfg2_decode
    import cfg2_pkg::*;
#(
    parameter int          AW        = 16,
    parameter logic [15:0] KEY_PORT  = 16'h0CF8,
    parameter logic [15:0] BUS_PORT  = 16'h0CFA,
    parameter logic [3:0]  WIN_NIB   = 4'hC
) (
    input  logic [AW-1:0] addr,
    input  xfer_size_e    size,
    input  logic          win_open,
    output dec_kind_e     kind
);
    localparam int NIB_LSB = 12;

    logic in_window;
    assign in_window = (addr[AW-1:NIB_LSB] == {{(AW-NIB_LSB-4){1'b0}}, WIN_NIB});

    always_comb begin
        kind = DEC_NONE;
        if (size != SZ_RSVD) begin
            if (win_open && in_window)
                kind = DEC_WINDOW;
            else if (size == SZ_BYTE && addr == AW'(KEY_PORT))
                kind = DEC_KEYREG;
            else if (size == SZ_BYTE && addr == AW'(BUS_PORT))
                kind = DEC_BUSREG;
        end
    end
endmodule

// File: rtl/cfg2_xfer.sv
module cfg2_xfer
    import cfg2_pkg::*;
#(
    parameter int DW   = 32,
    parameter int REGW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ctrl_start,
    input  logic            ctrl_rd,
    input  logic [REGW-1:0] ctrl_rdata,
    input  logic            win_start,
    input  logic            win_wr,
    input  xfer_size_e      win_size,
    input  logic [11:0]     win_off,
    input  logic [2:0]      win_func,
    input  logic [7:0]      win_bus,
    input  logic [DW-1:0]   win_wdata,
    output logic            busy,
    output logic            io_done,
    output logic [DW-1:0]   io_rdata,
    output logic            cfg_req,
    output logic            cfg_wr,
    output logic [7:0]      cfg_bus,
    output logic [3:0]      cfg_dev,
    output logic [2:0]      cfg_func,
    output logic [7:0]      cfg_reg,
    output logic [DW/8-1:0] cfg_be,
    output logic [DW-1:0]   cfg_wdata,
    input  logic            cfg_ack,
    input  logic            cfg_err,
    input  logic [DW-1:0]   cfg_rdata
);
    xfer_state_e state_q;
    xfer_size_e  size_q;
    logic [1:0]  shift_q;
    logic [1:0]  lo;
    logic [1:0]  off;

    assign lo      = win_off[1:0];
    assign off     = lane_offset(win_size, lo);
    assign busy    = (state_q == XF_WAIT);
    assign cfg_req = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= XF_IDLE;
            io_done   <= 1'b0;
            io_rdata  <= '0;
            cfg_wr    <= 1'b0;
            cfg_bus   <= '0;
            cfg_dev   <= '0;
            cfg_func  <= '0;
            cfg_reg   <= '0;
            cfg_be    <= '0;
            cfg_wdata <= '0;
            size_q    <= SZ_BYTE;
            shift_q   <= '0;
        end else begin
            io_done <= 1'b0;
            case (state_q)
                XF_IDLE: begin
                    if (ctrl_start) begin
                        io_done <= 1'b1;
                        if (ctrl_rd) io_rdata <= DW'(ctrl_rdata);
                    end else if (win_start) begin
                        state_q   <= XF_WAIT;
                        cfg_wr    <= win_wr;
                        cfg_bus   <= win_bus;
                        cfg_dev   <= win_off[11:8];
                        cfg_func  <= win_func;
                        cfg_reg   <= {win_off[7:2], 2'b00};
                        cfg_be    <= lane_enables(win_size, lo);
                        cfg_wdata <= (win_wdata & size_mask(win_size)) << (8 * off);
                        size_q    <= win_size;
                        shift_q   <= off;
                    end
                end
                XF_WAIT: begin
                    if (cfg_ack) begin
                        state_q <= XF_IDLE;
                        io_done <= 1'b1;
                        if (!cfg_wr) begin
                            if (cfg_err)
                                io_rdata <= '1;
                            else
                                io_rdata <= (cfg_rdata >> (8 * shift_q)) & size_mask(size_q);
                        end
                    end
                end
                default: state_q <= XF_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfg2_port_mapper.sv
module cfg2_port_mapper
    import cfg2_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          DW       = 32,
    parameter logic [15:0] KEY_PORT = 16'h0CF8,
    parameter logic [15:0] BUS_PORT = 16'h0CFA,
    parameter logic [3:0]  WIN_NIB  = 4'hC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            io_req,
    input  logic            io_wr,
    input  logic [AW-1:0]   io_addr,
    input  logic [1:0]      io_size,
    input  logic [DW-1:0]   io_wdata,
    output logic            io_hit,
    output logic            io_done,
    output logic [DW-1:0]   io_rdata,
    output logic            cfg_req,
    output logic            cfg_wr,
    output logic [7:0]      cfg_bus,
    output logic [3:0]      cfg_dev,
    output logic [2:0]      cfg_func,
    output logic [7:0]      cfg_reg,
    output logic [DW/8-1:0] cfg_be,
    output logic [DW-1:0]   cfg_wdata,
    input  logic            cfg_ack,
    input  logic            cfg_err,
    input  logic [DW-1:0]   cfg_rdata
);
    localparam int REGW = 8;

    logic [REGW-1:0] key_q;
    logic [REGW-1:0] bus_q;
    logic            win_open;
    logic            busy;
    dec_kind_e       kind;
    xfer_size_e      size;
    logic            is_ctrl;

    assign size     = xfer_size_e'(io_size);
    assign win_open = (key_q[7:4] != 4'h0);

    cfg2_decode #(
        .AW(AW), .KEY_PORT(KEY_PORT), .BUS_PORT(BUS_PORT), .WIN_NIB(WIN_NIB)
    ) i_decode (
        .addr(io_addr), .size(size), .win_open(win_open), .kind(kind)
    );

    assign io_hit  = io_req && !busy && (kind != DEC_NONE);
    assign is_ctrl = (kind == DEC_KEYREG) || (kind == DEC_BUSREG);

    cfg2_ctrl_regs #(.REG_W(REGW)) i_regs (
        .clk(clk), .rst(rst),
        .key_we(io_hit && io_wr && kind == DEC_KEYREG),
        .bus_we(io_hit && io_wr && kind == DEC_BUSREG),
        .wdata(io_wdata[REGW-1:0]),
        .key_q(key_q), .bus_q(bus_q)
    );

    cfg2_xfer #(.DW(DW), .REGW(REGW)) i_xfer (
        .clk(clk), .rst(rst),
        .ctrl_start(io_hit && is_ctrl),
        .ctrl_rd(!io_wr),
        .ctrl_rdata(kind == DEC_KEYREG ? key_q : bus_q),
        .win_start(io_hit && kind == DEC_WINDOW),
        .win_wr(io_wr),
        .win_size(size),
        .win_off(io_addr[11:0]),
        .win_func(key_q[3:1]),
        .win_bus(bus_q),
        .win_wdata(io_wdata),
        .busy(busy),
        .io_done(io_done),
        .io_rdata(io_rdata),
        .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
        .cfg_func(cfg_func), .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_ack(cfg_ack), .cfg_err(cfg_err), .cfg_rdata(cfg_rdata)
    );
endmodule

// File: rtl/cfg2_mapper_chk.sv
module cfg2_mapper_chk (
    input logic        clk,
    input logic        rst,
    input logic        io_req,
    input logic        io_hit,
    input logic        io_done,
    input logic [15:0] io_addr,
    input logic        cfg_req,
    input logic        cfg_ack,
    input logic [3:0]  cfg_be,
    input logic [7:0]  cfg_dev_off,
    input logic [7:0]  key_q
);
    // R3
    closed_window_chk: assert property (@(posedge clk) disable iff (rst)
        (io_req && key_q[7:4] == 4'h0 && io_addr[15:12] == 4'hC) |-> !io_hit);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && !cfg_ack) |=> cfg_req);

    // R11
    fields_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && !cfg_ack) |=> ($stable(cfg_be) && $stable(cfg_dev_off)));

    // R11
    ack_done_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && cfg_ack) |=> (io_done && !cfg_req));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        io_done |=> !io_done);

    // R5
    be_shape_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> ($countones(cfg_be) == 1 || cfg_be == 4'b0011 ||
                     cfg_be == 4'b1100 || cfg_be == 4'b1111));

    // R12
    busy_hit_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> !io_hit);
endmodule

bind cfg2_port_mapper cfg2_mapper_chk i_chk (
    .clk(clk), .rst(rst), .io_req(io_req), .io_hit(io_hit), .io_done(io_done),
    .io_addr(io_addr), .cfg_req(cfg_req), .cfg_ack(cfg_ack), .cfg_be(cfg_be),
    .cfg_dev_off({cfg_dev, cfg_reg[7:4]}), .key_q(key_q)
);

// File: tb/test_cfg2_port_mapper.sv
module test_cfg2_port_mapper;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_req = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [1:0]  io_size = '0;
    logic [31:0] io_wdata = '0;
    logic        io_hit, io_done;
    logic [31:0] io_rdata;
    logic        cfg_req, cfg_wr;
    logic [7:0]  cfg_bus, cfg_reg;
    logic [3:0]  cfg_dev, cfg_be;
    logic [2:0]  cfg_func;
    logic [31:0] cfg_wdata;
    logic        cfg_ack = 1'b0;
    logic        cfg_err = 1'b0;
    logic [31:0] cfg_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg2_port_mapper i_cfg2_port_mapper (.*);

    // Responder model: acknowledges after `lat` waiting cycles.
    int          lat = 0;
    int          wcnt = 0;
    logic [7:0]  r_bus, r_reg;
    logic [3:0]  r_dev, r_be;
    logic [2:0]  r_func;
    logic        r_wr;
    logic [31:0] r_wdata;
    int          n_reqs = 0;

    function automatic logic [31:0] model(input logic [7:0] b, input logic [3:0] d,
                                          input logic [2:0] f, input logic [7:0] r);
        return {b, d, 1'b0, f, r[7:2], 2'b11, 8'h5A};
    endfunction

    always @(negedge clk) begin
        cfg_ack = 1'b0;
        cfg_err = 1'b0;
        if (cfg_req) begin
            if (wcnt >= lat) begin
                cfg_ack   = 1'b1;
                cfg_err   = (cfg_dev >= 4'd12);
                cfg_rdata = model(cfg_bus, cfg_dev, cfg_func, cfg_reg);
                r_bus = cfg_bus; r_dev = cfg_dev; r_func = cfg_func; r_reg = cfg_reg;
                r_be = cfg_be; r_wr = cfg_wr; r_wdata = cfg_wdata;
                n_reqs++;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic        t_hit;
    logic [31:0] t_rd;
    int          t_cyc;

    task automatic io_do(input logic wr, input logic [15:0] a, input logic [1:0] sz, input logic [31:0] wd);
        @(negedge clk);
        io_req = 1'b1; io_wr = wr; io_addr = a; io_size = sz; io_wdata = wd;
        #1 t_hit = io_hit;
        @(negedge clk);
        io_req = 1'b0;
        t_cyc = 0;
        if (t_hit) begin
            while (!io_done && t_cyc < 100) begin
                @(negedge clk);
                t_cyc++;
            end
            if (!io_done) chk(1'b0, "timeout", 32'(t_cyc), 32'd100);
        end
        t_rd = io_rdata;
    endtask

    // Vector table: {addr, size, expected byte enables}
    localparam int NV = 9;
    localparam logic [21:0] VECS [NV] = '{
        {16'hC008, 2'd0, 4'b0001},
        {16'hC109, 2'd0, 4'b0010},
        {16'hC20A, 2'd0, 4'b0100},
        {16'hC30B, 2'd0, 4'b1000},
        {16'hC40C, 2'd1, 4'b0011},
        {16'hC50E, 2'd1, 4'b1100},
        {16'hC60F, 2'd1, 4'b1100},
        {16'hC710, 2'd2, 4'b1111},
        {16'hC813, 2'd2, 4'b1111}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] a;
        logic [1:0]  sz;
        logic [3:0]  ebe;
        logic [1:0]  off;
        logic [31:0] msk, exp;
        int reqs_before;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        io_do(1'b0, 16'h0CF8, 2'd0, 0);
        chk(t_hit && t_rd == 32'h0, "R1 key reg after reset", t_rd, 0);
        io_do(1'b0, 16'h0CFA, 2'd0, 0);
        chk(t_hit && t_rd == 32'h0, "R1 bus reg after reset", t_rd, 0);
        io_do(1'b0, 16'hC000, 2'd2, 0);
        chk(!t_hit, "R1 window closed after reset", 32'(t_hit), 0);

        // R2 control write/readback and timing
        io_do(1'b1, 16'h0CFA, 2'd0, 32'hFFFF_FF3C);
        chk(t_cyc == 0, "R2 control done latency", 32'(t_cyc), 0);
        io_do(1'b0, 16'h0CFA, 2'd0, 0);
        chk(t_rd == 32'h3C, "R2 bus reg readback", t_rd, 32'h3C);
        io_do(1'b1, 16'h0CF8, 2'd0, 32'h0000_00FA);
        io_do(1'b0, 16'h0CF8, 2'd0, 0);
        chk(t_rd == 32'hFA, "R2 key reg readback", t_rd, 32'hFA);

        // R4 R5 R7 table walk, function 5, bus 0x3C, zero-wait responder
        lat = 0;
        for (int i = 0; i < NV; i++) begin
            {a, sz, ebe} = VECS[i];
            io_do(1'b0, a, sz, 0);
            off = (sz == 2'd0) ? a[1:0] : (sz == 2'd1) ? {a[1], 1'b0} : 2'd0;
            msk = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
            exp = (model(8'h3C, a[11:8], 3'd5, {a[7:2], 2'b00}) >> (8 * off)) & msk;
            chk(t_hit, "R4 window claimed", 32'(t_hit), 1);
            chk(r_be == ebe, "R5 byte enables", 32'(r_be), 32'(ebe));
            chk(r_dev == a[11:8] && r_reg == {a[7:2], 2'b00} && r_func == 3'd5 && r_bus == 8'h3C,
                "R4 decode", {r_bus, r_dev, 1'b0, r_func, r_reg, 8'h0},
                {8'h3C, a[11:8], 1'b0, 3'd5, a[7:2], 2'b00, 8'h0});
            chk(t_rd == exp, "R7 read data", t_rd, exp);
            // R11 zero-wait acknowledge completes one cycle after launch
            chk(t_cyc == 1, "R11 zero-wait completion", 32'(t_cyc), 1);
        end

        // R6 write lanes
        io_do(1'b1, 16'hC10B, 2'd0, 32'hABCD_EF77);
        chk(r_wr && r_be == 4'b1000 && r_wdata[31:24] == 8'h77, "R6 byte write lane", r_wdata, 32'h7700_0000);
        io_do(1'b1, 16'hC20E, 2'd1, 32'h1234_BEEF);
        chk(r_be == 4'b1100 && r_wdata == 32'hBEEF_0000, "R6 word write lane", r_wdata, 32'hBEEF_0000);
        io_do(1'b1, 16'hC304, 2'd2, 32'hCAFE_F00D);
        chk(r_be == 4'b1111 && r_wdata == 32'hCAFE_F00D, "R6 dword write", r_wdata, 32'hCAFE_F00D);

        // R8 absent device
        io_do(1'b0, 16'hCD02, 2'd1, 0);
        chk(t_rd == 32'hFFFF_FFFF, "R8 no device read", t_rd, 32'hFFFF_FFFF);

        // R9 unclaimed addresses
        io_do(1'b0, 16'hB000, 2'd2, 0);
        chk(!t_hit, "R9 below window", 32'(t_hit), 0);
        io_do(1'b0, 16'hD000, 2'd0, 0);
        chk(!t_hit, "R9 above window", 32'(t_hit), 0);
        io_do(1'b1, 16'h0CF9, 2'd0, 0);
        chk(!t_hit, "R9 port 0xCF9", 32'(t_hit), 0);

        // R10 size rules
        io_do(1'b1, 16'h0CF8, 2'd1, 0);
        chk(!t_hit, "R10 word to key port", 32'(t_hit), 0);
        io_do(1'b0, 16'hC000, 2'd3, 0);
        chk(!t_hit, "R10 reserved size", 32'(t_hit), 0);
        io_do(1'b0, 16'h0CF8, 2'd0, 0);
        chk(t_rd == 32'hFA, "R10 key reg kept", t_rd, 32'hFA);

        // R11 slow responder
        lat = 2;
        io_do(1'b0, 16'hC100, 2'd2, 0);
        chk(t_cyc == 3, "R11 wait-state completion", 32'(t_cyc), 3);

        // R12 request while busy
        lat = 6;
        @(negedge clk);
        io_req = 1'b1; io_wr = 1'b0; io_addr = 16'hC200; io_size = 2'd2;
        @(negedge clk);
        io_req = 1'b0;
        @(negedge clk);
        io_req = 1'b1; io_wr = 1'b1; io_addr = 16'h0CF8; io_size = 2'd0; io_wdata = 32'h0;
        #1 chk(!io_hit, "R12 busy not claimed", 32'(io_hit), 0);
        @(negedge clk);
        io_req = 1'b0;
        while (!io_done) @(negedge clk);
        lat = 0;
        io_do(1'b0, 16'h0CF8, 2'd0, 0);
        chk(t_rd == 32'hFA, "R12 key reg untouched", t_rd, 32'hFA);

        // R3 closed window with non-zero low bits
        io_do(1'b1, 16'h0CF8, 2'd0, 32'h0E);
        reqs_before = n_reqs;
        io_do(1'b0, 16'hC000, 2'd2, 0);
        chk(!t_hit, "R3 key zero not claimed", 32'(t_hit), 0);
        repeat (3) @(negedge clk);
        chk(n_reqs == reqs_before && !cfg_req, "R3 no request issued", 32'(n_reqs), 32'(reqs_before));

        // R2 zero detection
        io_do(1'b1, 16'h0CF8, 2'd0, 0);
        io_do(1'b1, 16'h0CFA, 2'd0, 0);
        io_do(1'b0, 16'h0CF8, 2'd0, 0);
        chk(t_rd == 0, "R2 key zero readback", t_rd, 0);
        io_do(1'b0, 16'h0CFA, 2'd0, 0);
        chk(t_rd == 0, "R2 bus zero readback", t_rd, 0);

        // R1 reset after use
        io_do(1'b1, 16'h0CF8, 2'd0, 32'hF2);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        io_do(1'b0, 16'h0CF8, 2'd0, 0);
        chk(t_rd == 0, "R1 key cleared by reset", t_rd, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule